// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block tells an out-of-order core which older store a memory instruction should wait behind. Instructions whose PCs have been caught in an ordering violation are grouped into a store set. Each set remembers the sequence number of its most recently dispatched store. A lookup by PC returns that sequence number, so the scheduler can hold the instruction until that store has issued.

There are two tables. The set-ID table is indexed by PC and holds a set ID plus a valid bit per entry. The last-store table is indexed by set ID and holds a sequence number plus a valid bit. A population counter for each set counts the stores assigned to it. When two sets collide during training, the counters decide which set survives.

Lookups are combinational. Every table update takes effect at the next rising clock edge. Violation detection, the load/store queue and the issue queue are outside this block.

Top module: `store_set_pred`

## Requirements
- R1: A PC selects set-ID entry `pc[IDX_W+1:2]`, where IDX_W = log2(SSIT_DEPTH). PCs that differ only in bits 1:0, or only above bit IDX_W+1, share an entry.
- R2: On a violation where neither the load's nor the store's set-ID entry is valid, both entries are marked valid and given a new set ID. The new ID is the load's set-ID index modulo LFST_DEPTH. That set's counter is incremented.
- R3: On a violation where only the load's entry is valid, the store's entry takes the load's set ID and becomes valid. The counter of that set is incremented.
- R4: On a violation where only the store's entry is valid, the load's entry takes the store's set ID and becomes valid. No counter changes.
- R5: On a violation where both entries are valid, the two set counters are compared.
  - If the load's set counter is strictly larger, the store moves into the load's set. The load-set counter is incremented and the store-set counter is decremented.
  - Otherwise the load moves into the store's set. The store-set counter is incremented and the load-set counter is decremented.
  - Counters saturate at zero and at their maximum.
- R6: A store dispatch whose set-ID entry is valid writes its sequence number into its set's last-store entry and marks that entry valid. A dispatch with an invalid set-ID entry changes nothing.
- R7: In the same cycle, a lookup returns hit=1 and the stored sequence number only when both the set-ID entry and the last-store entry are valid. Otherwise it returns hit=0 and sequence 0.
- R8: An issue with the store flag set invalidates its set's last-store entry only if that entry holds exactly the issuing sequence number. An issue with the store flag clear has no effect.
- R9: A squash invalidates every last-store entry whose sequence number is greater than or equal to the squash sequence number.
- R10: Clear invalidates every entry of both tables. Reset does the same and also zeroes all set counters.
- R11: Updates to a last-store entry in the same cycle are resolved by fixed priority, highest first: clear, dispatch write, squash, store-issue release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| viol_valid_i | input | 1 | Train on an ordering violation |
| viol_ld_pc_i | input | PC_W | PC of the violating load |
| viol_st_pc_i | input | PC_W | PC of the store it overtook |
| disp_valid_i | input | 1 | Store dispatched |
| disp_pc_i | input | PC_W | PC of the dispatched store |
| disp_seq_i | input | SEQ_W | Sequence number of the dispatched store |
| look_pc_i | input | PC_W | PC to look up |
| look_seq_o | output | SEQ_W | Sequence number of the store to wait for, 0 on miss |
| look_hit_o | output | 1 | A dependence was found |
| iss_valid_i | input | 1 | Instruction issued |
| iss_pc_i | input | PC_W | PC of the issued instruction |
| iss_seq_i | input | SEQ_W | Sequence number of the issued instruction |
| iss_is_store_i | input | 1 | Issued instruction is a store |
| squash_valid_i | input | 1 | Squash request |
| squash_seq_i | input | SEQ_W | Lowest squashed sequence number |
| clear_i | input | 1 | Invalidate both tables |

## Verification
On every cycle the assertions check the following through the lookup port:
- Clear leaves nothing to hit in the next cycle.
- A squash leaves no hit at or above its sequence number.
- A matching store issue releases the entry being looked up.
- A dispatch to a trained PC shows up on the next cycle.

The training cases need scripted bench scenarios, because their effects appear only through later dispatches and lookups. These cases are new-set creation, joining a set in either direction, and counter-driven merges including ties and saturation at zero. The same holds for PC aliasing and for same-cycle priority between dispatch, squash and issue.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [2:0] {
    TR_IDLE,
    TR_NEW,
    TR_JOIN_LD,
    TR_JOIN_ST,
    TR_MOVE_ST,
    TR_MOVE_LD
  } train_e;
endpackage

// File: rtl/ssp_ssit.sv
module ssp_ssit #(
  parameter int PC_W   = 32,
  parameter int DEPTH  = 64,
  parameter int SSID_W = 4,
  parameter int NRD    = 5,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          clear_i,
  input  logic [NRD-1:0][PC_W-1:0]      rd_pc_i,
  output logic [NRD-1:0]                rd_vld_o,
  output logic [NRD-1:0][SSID_W-1:0]    rd_id_o,
  output logic [NRD-1:0][IDX_W-1:0]     rd_idx_o,
  input  logic [1:0]                    wr_en_i,
  input  logic [1:0][IDX_W-1:0]         wr_idx_i,
  input  logic [SSID_W-1:0]             wr_id_i
);
  logic [DEPTH-1:0]  vld_q;
  logic [SSID_W-1:0] id_q [DEPTH];

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [IDX_W-1:0] idx;
    assign idx         = rd_pc_i[r][IDX_W+1:2];
    assign rd_idx_o[r] = idx;
    assign rd_vld_o[r] = vld_q[idx];
    assign rd_id_o[r]  = id_q[idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (clear_i) vld_q <= '0;
    else begin
      if (wr_en_i[0]) vld_q[wr_idx_i[0]] <= 1'b1;
      if (wr_en_i[1]) vld_q[wr_idx_i[1]] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int w = 0; w < 2; w++)
      if (wr_en_i[w]) id_q[wr_idx_i[w]] <= wr_id_i;
  end
endmodule

// File: rtl/ssp_ctr.sv
module ssp_ctr #(
  parameter int N      = 16,
  parameter int SSID_W = 4,
  parameter int CNT_W  = 7
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      inc_en_i,
  input  logic [SSID_W-1:0]         inc_id_i,
  input  logic                      dec_en_i,
  input  logic [SSID_W-1:0]         dec_id_i,
  output logic [N-1:0][CNT_W-1:0]   cnt_o
);
  for (genvar s = 0; s < N; s++) begin : g_set
    logic [CNT_W-1:0] cnt_q;
    logic inc_s, dec_s;
    assign inc_s    = inc_en_i && (inc_id_i == SSID_W'(s));
    assign dec_s    = dec_en_i && (dec_id_i == SSID_W'(s));
    assign cnt_o[s] = cnt_q;

    // inc and dec of the same set cancel; saturate both ways
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else if (inc_s && !dec_s && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      else if (dec_s && !inc_s && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/ssp_lfst.sv
module ssp_lfst #(
  parameter int N      = 16,
  parameter int SSID_W = 4,
  parameter int SEQ_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              disp_en_i,
  input  logic [SSID_W-1:0] disp_id_i,
  input  logic [SEQ_W-1:0]  disp_seq_i,
  input  logic              iss_en_i,
  input  logic [SSID_W-1:0] iss_id_i,
  input  logic [SEQ_W-1:0]  iss_seq_i,
  input  logic              sq_en_i,
  input  logic [SEQ_W-1:0]  sq_seq_i,
  input  logic [SSID_W-1:0] rd_id_i,
  output logic              rd_vld_o,
  output logic [SEQ_W-1:0]  rd_seq_o
);
  logic [N-1:0]            vld_all;
  logic [N-1:0][SEQ_W-1:0] seq_all;

  for (genvar e = 0; e < N; e++) begin : g_ent
    logic             vld_q;
    logic [SEQ_W-1:0] seq_q;
    logic disp_s, iss_s, sq_s;
    assign disp_s     = disp_en_i && (disp_id_i == SSID_W'(e));
    assign iss_s      = iss_en_i && (iss_id_i == SSID_W'(e)) && (seq_q == iss_seq_i);
    assign sq_s       = sq_en_i && (seq_q >= sq_seq_i);
    assign vld_all[e] = vld_q;
    assign seq_all[e] = seq_q;

    // priority: clear > dispatch > squash > issue release
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= 1'b0;
        seq_q <= '0;
      end else if (clear_i) begin
        vld_q <= 1'b0;
      end else if (disp_s) begin
        vld_q <= 1'b1;
        seq_q <= disp_seq_i;
      end else if (sq_s || iss_s) begin
        vld_q <= 1'b0;
      end
    end
  end

  assign rd_vld_o = vld_all[rd_id_i];
  assign rd_seq_o = seq_all[rd_id_i];
endmodule

// File: rtl/ssp_train.sv
module ssp_train import ssp_pkg::*; #(
  parameter int SSID_W = 4,
  parameter int CNT_W  = 7
) (
  input  logic              en_i,
  input  logic              ld_vld_i,
  input  logic              st_vld_i,
  input  logic [SSID_W-1:0] ld_id_i,
  input  logic [SSID_W-1:0] st_id_i,
  input  logic [SSID_W-1:0] new_id_i,
  input  logic [CNT_W-1:0]  ld_cnt_i,
  input  logic [CNT_W-1:0]  st_cnt_i,
  output logic              wr_ld_o,
  output logic              wr_st_o,
  output logic [SSID_W-1:0] wr_id_o,
  output logic              inc_en_o,
  output logic [SSID_W-1:0] inc_id_o,
  output logic              dec_en_o,
  output logic [SSID_W-1:0] dec_id_o
);
  train_e kind;

  always_comb begin
    if (!en_i)                      kind = TR_IDLE;
    else if (!ld_vld_i && !st_vld_i) kind = TR_NEW;
    else if (!st_vld_i)             kind = TR_JOIN_LD;
    else if (!ld_vld_i)             kind = TR_JOIN_ST;
    else if (ld_cnt_i > st_cnt_i)   kind = TR_MOVE_ST;
    else                            kind = TR_MOVE_LD;
  end

  always_comb begin
    wr_ld_o  = 1'b0;
    wr_st_o  = 1'b0;
    wr_id_o  = '0;
    inc_en_o = 1'b0;
    inc_id_o = '0;
    dec_en_o = 1'b0;
    dec_id_o = '0;
    case (kind)
      TR_NEW: begin
        wr_ld_o = 1'b1; wr_st_o = 1'b1; wr_id_o = new_id_i;
        inc_en_o = 1'b1; inc_id_o = new_id_i;
      end
      TR_JOIN_LD: begin
        wr_st_o = 1'b1; wr_id_o = ld_id_i;
        inc_en_o = 1'b1; inc_id_o = ld_id_i;
      end
      TR_JOIN_ST: begin
        wr_ld_o = 1'b1; wr_id_o = st_id_i;
      end
      TR_MOVE_ST: begin
        wr_st_o = 1'b1; wr_id_o = ld_id_i;
        inc_en_o = 1'b1; inc_id_o = ld_id_i;
        dec_en_o = 1'b1; dec_id_o = st_id_i;
      end
      TR_MOVE_LD: begin
        wr_ld_o = 1'b1; wr_id_o = st_id_i;
        inc_en_o = 1'b1; inc_id_o = st_id_i;
        dec_en_o = 1'b1; dec_id_o = ld_id_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/store_set_pred.sv
module store_set_pred #(
  parameter int PC_W       = 32,
  parameter int SEQ_W      = 16,
  parameter int SSIT_DEPTH = 64,
  parameter int LFST_DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             viol_valid_i,
  input  logic [PC_W-1:0]  viol_ld_pc_i,
  input  logic [PC_W-1:0]  viol_st_pc_i,
  input  logic             disp_valid_i,
  input  logic [PC_W-1:0]  disp_pc_i,
  input  logic [SEQ_W-1:0] disp_seq_i,
  input  logic [PC_W-1:0]  look_pc_i,
  output logic [SEQ_W-1:0] look_seq_o,
  output logic             look_hit_o,
  input  logic             iss_valid_i,
  input  logic [PC_W-1:0]  iss_pc_i,
  input  logic [SEQ_W-1:0] iss_seq_i,
  input  logic             iss_is_store_i,
  input  logic             squash_valid_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  input  logic             clear_i
);
  localparam int IDX_W  = $clog2(SSIT_DEPTH);
  localparam int SSID_W = $clog2(LFST_DEPTH);
  localparam int CNT_W  = $clog2(SSIT_DEPTH + 1);
  localparam int NRD    = 5;
  localparam int P_LD = 0, P_ST = 1, P_DSP = 2, P_ISS = 3, P_LK = 4;

  if (SSIT_DEPTH != (1 << IDX_W) || LFST_DEPTH != (1 << SSID_W) ||
      LFST_DEPTH > SSIT_DEPTH) begin : g_bad_cfg
    $error("store_set_pred: depths must be powers of two, LFST_DEPTH <= SSIT_DEPTH");
  end

  logic [NRD-1:0][PC_W-1:0]   rd_pc;
  logic [NRD-1:0]             rd_vld;
  logic [NRD-1:0][SSID_W-1:0] rd_id;
  logic [NRD-1:0][IDX_W-1:0]  rd_idx;

  logic                       wr_ld, wr_st;
  logic [SSID_W-1:0]          wr_id;
  logic                       inc_en, dec_en;
  logic [SSID_W-1:0]          inc_id, dec_id;
  logic [LFST_DEPTH-1:0][CNT_W-1:0] cnt;

  logic                       lf_vld;
  logic [SEQ_W-1:0]           lf_seq;

  assign rd_pc = {look_pc_i, iss_pc_i, disp_pc_i, viol_st_pc_i, viol_ld_pc_i};

  ssp_ssit #(
    .PC_W(PC_W), .DEPTH(SSIT_DEPTH), .SSID_W(SSID_W), .NRD(NRD), .IDX_W(IDX_W)
  ) u_ssit (
    .clk_i, .rst_ni, .clear_i,
    .rd_pc_i  (rd_pc),
    .rd_vld_o (rd_vld),
    .rd_id_o  (rd_id),
    .rd_idx_o (rd_idx),
    .wr_en_i  ({wr_st, wr_ld}),
    .wr_idx_i ({rd_idx[P_ST], rd_idx[P_LD]}),
    .wr_id_i  (wr_id)
  );

  ssp_train #(.SSID_W(SSID_W), .CNT_W(CNT_W)) u_train (
    .en_i     (viol_valid_i),
    .ld_vld_i (rd_vld[P_LD]),
    .st_vld_i (rd_vld[P_ST]),
    .ld_id_i  (rd_id[P_LD]),
    .st_id_i  (rd_id[P_ST]),
    .new_id_i (rd_idx[P_LD][SSID_W-1:0]),
    .ld_cnt_i (cnt[rd_id[P_LD]]),
    .st_cnt_i (cnt[rd_id[P_ST]]),
    .wr_ld_o  (wr_ld),
    .wr_st_o  (wr_st),
    .wr_id_o  (wr_id),
    .inc_en_o (inc_en),
    .inc_id_o (inc_id),
    .dec_en_o (dec_en),
    .dec_id_o (dec_id)
  );

  ssp_ctr #(.N(LFST_DEPTH), .SSID_W(SSID_W), .CNT_W(CNT_W)) u_ctr (
    .clk_i, .rst_ni,
    .inc_en_i (inc_en),
    .inc_id_i (inc_id),
    .dec_en_i (dec_en),
    .dec_id_i (dec_id),
    .cnt_o    (cnt)
  );

  ssp_lfst #(.N(LFST_DEPTH), .SSID_W(SSID_W), .SEQ_W(SEQ_W)) u_lfst (
    .clk_i, .rst_ni, .clear_i,
    .disp_en_i  (disp_valid_i && rd_vld[P_DSP]),
    .disp_id_i  (rd_id[P_DSP]),
    .disp_seq_i (disp_seq_i),
    .iss_en_i   (iss_valid_i && iss_is_store_i && rd_vld[P_ISS]),
    .iss_id_i   (rd_id[P_ISS]),
    .iss_seq_i  (iss_seq_i),
    .sq_en_i    (squash_valid_i),
    .sq_seq_i   (squash_seq_i),
    .rd_id_i    (rd_id[P_LK]),
    .rd_vld_o   (lf_vld),
    .rd_seq_o   (lf_seq)
  );

  assign look_hit_o = rd_vld[P_LK] && lf_vld;
  assign look_seq_o = look_hit_o ? lf_seq : '0;
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
  parameter int PC_W  = 32,
  parameter int SEQ_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             viol_valid_i,
  input logic             disp_valid_i,
  input logic [PC_W-1:0]  disp_pc_i,
  input logic [SEQ_W-1:0] disp_seq_i,
  input logic [PC_W-1:0]  look_pc_i,
  input logic [SEQ_W-1:0] look_seq_o,
  input logic             look_hit_o,
  input logic             iss_valid_i,
  input logic [PC_W-1:0]  iss_pc_i,
  input logic [SEQ_W-1:0] iss_seq_i,
  input logic             iss_is_store_i,
  input logic             squash_valid_i,
  input logic [SEQ_W-1:0] squash_seq_i,
  input logic             clear_i
);
  // R10
  clear_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !look_hit_o);

  // R9
  squash_kills_young_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_valid_i && !disp_valid_i |=>
      !(look_hit_o && look_seq_o >= $past(squash_seq_i)));

  // R8
  issue_releases_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_valid_i && iss_is_store_i && !disp_valid_i && !viol_valid_i &&
    look_hit_o && look_pc_i == iss_pc_i && look_seq_o == iss_seq_i |=>
      (look_pc_i != $past(look_pc_i)) || !look_hit_o);

  // R6
  dispatch_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_i && !clear_i && !viol_valid_i && look_hit_o &&
    look_pc_i == disp_pc_i |=>
      (look_pc_i != $past(look_pc_i)) ||
      (look_hit_o && look_seq_o == $past(disp_seq_i)));
endmodule

bind store_set_pred ssp_chk #(.PC_W(PC_W), .SEQ_W(SEQ_W)) u_chk (.*);

// File: tb/tb_store_set_pred.sv
`timescale 1ns/1ps
module tb_store_set_pred;
  localparam int PC_W  = 32;
  localparam int SEQ_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             viol_valid_i = 1'b0;
  logic [PC_W-1:0]  viol_ld_pc_i = '0, viol_st_pc_i = '0;
  logic             disp_valid_i = 1'b0;
  logic [PC_W-1:0]  disp_pc_i = '0;
  logic [SEQ_W-1:0] disp_seq_i = '0;
  logic [PC_W-1:0]  look_pc_i = '0;
  logic [SEQ_W-1:0] look_seq_o;
  logic             look_hit_o;
  logic             iss_valid_i = 1'b0;
  logic [PC_W-1:0]  iss_pc_i = '0;
  logic [SEQ_W-1:0] iss_seq_i = '0;
  logic             iss_is_store_i = 1'b0;
  logic             squash_valid_i = 1'b0;
  logic [SEQ_W-1:0] squash_seq_i = '0;
  logic             clear_i = 1'b0;

  store_set_pred #(.PC_W(PC_W), .SEQ_W(SEQ_W), .SSIT_DEPTH(64), .LFST_DEPTH(16)) dut (.*);

  always #2.5 clk_i = ~clk_i;

  typedef struct {
    logic             hit;
    logic [SEQ_W-1:0] seq;
    string            tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  // monitor: compare combinational lookup mid-cycle
  exp_t e;
  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (look_hit_o !== e.hit || look_seq_o !== e.seq) begin
        errors++;
        $display("FAIL %s: actual hit=%0b seq=%0d expected hit=%0b seq=%0d",
                 e.tag, look_hit_o, look_seq_o, e.hit, e.seq);
      end
    end
  end

  function automatic logic [PC_W-1:0] pc(int idx, int hi = 0, int lo = 0);
    return PC_W'((hi << 12) | (idx << 2) | lo);
  endfunction

  task automatic tick();
    @(posedge clk_i); #1;
    viol_valid_i = 1'b0; disp_valid_i = 1'b0; iss_valid_i = 1'b0;
    squash_valid_i = 1'b0; clear_i = 1'b0;
  endtask

  task automatic set_disp(logic [PC_W-1:0] p, int s);
    disp_valid_i = 1'b1; disp_pc_i = p; disp_seq_i = SEQ_W'(s);
  endtask
  task automatic set_iss(logic [PC_W-1:0] p, int s, logic st);
    iss_valid_i = 1'b1; iss_pc_i = p; iss_seq_i = SEQ_W'(s); iss_is_store_i = st;
  endtask
  task automatic set_sq(int s);
    squash_valid_i = 1'b1; squash_seq_i = SEQ_W'(s);
  endtask

  task automatic viol(logic [PC_W-1:0] l, logic [PC_W-1:0] s);
    viol_valid_i = 1'b1; viol_ld_pc_i = l; viol_st_pc_i = s; tick();
  endtask
  task automatic disp(logic [PC_W-1:0] p, int s);
    set_disp(p, s); tick();
  endtask
  task automatic issue(logic [PC_W-1:0] p, int s, logic st);
    set_iss(p, s, st); tick();
  endtask
  task automatic squash(int s);
    set_sq(s); tick();
  endtask
  task automatic look(logic [PC_W-1:0] p, logic h, int s, string tag);
    exp_t x;
    look_pc_i = p;
    x.hit = h; x.seq = SEQ_W'(s); x.tag = tag;
    q.push_back(x);
    tick();
  endtask

  // set-ID indices: loads 19,32,33,42,44,46  stores 5,7,9,11,13,15
  localparam int L1 = 19, L2 = 32, L3 = 33, L4 = 42, L5 = 44, L6 = 46;
  localparam int S1 = 5, S2 = 7, S3 = 9, S4 = 11, S5 = 13, S6 = 15;

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    look(pc(L1), 0, 0, "R10 reset empty");
    disp(pc(S1), 50);
    look(pc(S1), 0, 0, "R6 untrained dispatch ignored");

    viol(pc(L1), pc(S1));                      // new set 3
    look(pc(S1), 0, 0, "R7 no last store yet");
    disp(pc(S1), 100);
    look(pc(S1), 1, 100, "R6 dispatch recorded");
    look(pc(L1), 1, 100, "R2 load shares new set");
    look(pc(S1, 5, 3), 1, 100, "R1 index alias");
    look(pc(S1 + 1), 0, 0, "R1 neighbour index");

    issue(pc(S1), 100, 1'b0);
    look(pc(S1), 1, 100, "R8 non-store issue ignored");
    issue(pc(S1), 99, 1'b1);
    look(pc(S1), 1, 100, "R8 mismatched seq kept");
    issue(pc(S1), 100, 1'b1);
    look(pc(S1), 0, 0, "R8 matching store releases");

    viol(pc(L1), pc(S2));                      // S2 joins set 3
    disp(pc(S2), 200);
    look(pc(L1), 1, 200, "R3 store joins load set");

    viol(pc(L2), pc(S3));                      // new set 0
    viol(pc(L3), pc(S3));                      // L3 joins set 0
    disp(pc(S3), 300);
    look(pc(L3), 1, 300, "R4 load joins store set");

    viol(pc(L1), pc(S3));                      // cnt3=2 > cnt0=1: S3 -> set 3
    disp(pc(S3), 400);
    look(pc(L1), 1, 400, "R5 store moved to larger load set");
    look(pc(L2), 1, 300, "R5 old set untouched");

    viol(pc(L4), pc(S4));                      // new set 10
    look(pc(L4), 0, 0, "R7 fresh set misses");
    viol(pc(L4), pc(S1));                      // cnt10=1 <= cnt3: L4 -> set 3
    look(pc(L4), 1, 400, "R5 load moved to larger store set");

    viol(pc(L5), pc(S5));                      // set 12
    viol(pc(L6), pc(S6));                      // set 14
    viol(pc(L5), pc(S6));                      // tie: L5 -> set 14
    disp(pc(S6), 500);
    look(pc(L5), 1, 500, "R5 tie goes to store set");
    viol(pc(L6), pc(S5));                      // cnt14=2 > cnt12=0: S5 -> set 14
    disp(pc(S5), 600);
    look(pc(L6), 1, 600, "R5 counters after merge");

    squash(500);
    look(pc(L6), 0, 0, "R9 younger store squashed");
    look(pc(L1), 1, 400, "R9 older store kept");
    squash(400);
    look(pc(L1), 0, 0, "R9 equal seq squashed");
    look(pc(L2), 1, 300, "R9 older set kept");

    set_disp(pc(S1), 700); set_sq(0); tick();
    look(pc(S1), 1, 700, "R11 dispatch beats squash");
    look(pc(L2), 0, 0, "R9 squash at zero");
    set_disp(pc(S1), 800); set_iss(pc(S1), 700, 1'b1); tick();
    look(pc(S1), 1, 800, "R11 dispatch beats issue");
    set_disp(pc(S1), 900); clear_i = 1'b1; tick();
    look(pc(S1), 0, 0, "R11 clear beats dispatch");
    disp(pc(S1), 1000);
    look(pc(S1), 0, 0, "R10 clear invalidated set-ID table");
    look(pc(L5), 0, 0, "R10 clear all");

    repeat (2) @(posedge clk_i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all): actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule